// File: doc/BRIEF.md
# Two-stage watchdog alarm controller

This block is a watchdog with two nested timeouts. An early soft stage and a later hard stage both count a periodic `tick` input. Each tick stands for one 290 ms time unit, and a faster tick can replace it in simulation. A `kick` input services the watchdog and restarts both stages. When the global enable is low, both stages are held idle at zero.

When the soft stage expires, the block raises a soft status flag, issues a reset pulse and strobes `bandCommit`. That strobe tells the clock logic to adopt a band change it has been holding back.

When the hard stage expires, the block raises a hard status flag and issues a reset pulse. It also strobes `safeSelect`, which moves the CPU and AGP/PCI clocks to their safe-return frequencies. It strobes `cpuModeClr` and `agpModeClr` to drop the two direct-programming mode bits. If relatch is enabled, it pulses `relatchStrobe` and captures the three hardware frequency-select straps.

Both stage limits are fields supplied by the register bank, and a limit of 0 turns its stage off. For correct use, the soft limit must be smaller than the hard limit.

Top module: `wdog_alarm_top`

## Requirements
- R1: While `rstN` is low, and right after it, every output is 0 and `strapValue` is 0.
- R2: Take `wdEnable`=1, `softEnable`=1 and `softLimit`=S≠0. On the S-th tick after the last kick or enable, `bandCommit` pulses high for one cycle and `softStatus` becomes 1. Both happen in the cycle after the edge that samples that tick.
- R3: Each alarm, soft or hard, drives `resetOut` high for exactly 4 cycles, starting in the cycle after the alarm edge. A new alarm during the pulse restarts the 4-cycle count.
- R4: Take `wdEnable`=1 and `hardLimit`=H≠0. On the H-th tick, `safeSelect`, `cpuModeClr` and `agpModeClr` pulse together for one cycle, and `hardStatus` becomes 1.
- R5: When `relatchEnable`=1, a hard alarm also pulses `relatchStrobe`, and `strapValue` takes the value of `strapIn` at the alarm edge. When `relatchEnable`=0, neither happens.
- R6: When `softEnable`=0, the soft stage never alarms, and the hard stage keeps working.
- R7: A cycle with `kick`=1 clears both stage counts. A tick in the same cycle as a kick is not counted.
- R8: While `wdEnable`=0, both counts are held at zero and no alarm occurs. Once the block is enabled again, counting starts from zero.
- R9: A limit of 0 turns that stage off, so it never alarms.
- R10: Each stage alarms at most once until the next kick or disable, however many more ticks arrive.
- R11: A status flag stays at 1 until its clear input is 1 for a cycle. If an alarm and a clear fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per timer unit |
| kick | input | 1 | Service pulse, restarts both stages |
| wdEnable | input | 1 | Global watchdog enable |
| softEnable | input | 1 | Soft stage enable |
| relatchEnable | input | 1 | Capture straps on hard alarm |
| softLimit | input | 4 | Soft timeout in tick units, 0 = off |
| hardLimit | input | 8 | Hard timeout in tick units, 0 = off |
| strapIn | input | 3 | Hardware frequency-select straps |
| clrSoftStatus | input | 1 | Write-one clear of soft status |
| clrHardStatus | input | 1 | Write-one clear of hard status |
| resetOut | output | 1 | Reset pulse, 4 cycles |
| softStatus | output | 1 | Soft alarm has occurred |
| hardStatus | output | 1 | Hard alarm has occurred |
| bandCommit | output | 1 | Commit pending PLL band |
| safeSelect | output | 1 | Force safe-return frequencies |
| cpuModeClr | output | 1 | Clear CPU direct-programming mode bit |
| agpModeClr | output | 1 | Clear AGP/PCI direct-programming mode bit |
| relatchStrobe | output | 1 | Straps were re-sampled |
| strapValue | output | 3 | Last captured strap value |

## Verification
All strobes, status flags and `strapValue` are due one cycle after the rising edge that samples the deciding tick. `resetOut` rises at that same point and stays high for the next four cycles. The bench's reference model steps on each rising edge and uses the inputs held stable since the previous falling edge. Every output is compared with the model at the falling edge that follows. Directed scenarios count strobe cycles over a whole phase and read those counts only after a settling cycle, so a late or repeated strobe still shows up.

// File: rtl/wdog_alarm_pkg.sv
package wdog_alarm_pkg;

  // Commands from the control to the counter datapath
  typedef struct packed {
    logic softClr;
    logic softInc;
    logic hardClr;
    logic hardInc;
  } cnt_cmd_t;

  // Limit flags returned by the datapath
  typedef struct packed {
    logic softAtLimit;
    logic hardAtLimit;
  } cnt_flag_t;

endpackage

// File: rtl/wdog_alarm_dp.sv
module wdog_alarm_dp
  import wdog_alarm_pkg::*;
#(
  parameter int SOFT_W = 4,
  parameter int HARD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SOFT_W-1:0] softLimit,
  input  logic [HARD_W-1:0] hardLimit,
  input  cnt_cmd_t          cmd,
  output cnt_flag_t         flags
);

  localparam int SOFT_EW = SOFT_W + 1;
  localparam int HARD_EW = HARD_W + 1;

  logic [SOFT_W-1:0] softCnt;
  logic [HARD_W-1:0] hardCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            softCnt <= '0;
    else if (cmd.softClr) softCnt <= '0;
    else if (cmd.softInc) softCnt <= softCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            hardCnt <= '0;
    else if (cmd.hardClr) hardCnt <= '0;
    else if (cmd.hardInc) hardCnt <= hardCnt + 1'b1;
  end

  // Reaching or passing the limit on this tick: a limit lowered mid-count fires at once
  always_comb begin
    flags.softAtLimit = ({1'b0, softCnt} + SOFT_EW'(1)) >= {1'b0, softLimit};
    flags.hardAtLimit = ({1'b0, hardCnt} + HARD_EW'(1)) >= {1'b0, hardLimit};
  end

  // R10: once a stage expires, the control stops advancing it
  p_soft_once_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.softInc && flags.softAtLimit) |=> !cmd.softInc);
  p_hard_once_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.hardInc && flags.hardAtLimit) |=> !cmd.hardInc);

endmodule

// File: rtl/wdog_alarm_ctl.sv
module wdog_alarm_ctl
  import wdog_alarm_pkg::*;
#(
  parameter int SOFT_W  = 4,
  parameter int HARD_W  = 8,
  parameter int STRAP_W = 3,
  parameter int RST_LEN = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               kick,
  input  logic               wdEnable,
  input  logic               softEnable,
  input  logic               relatchEnable,
  input  logic [SOFT_W-1:0]  softLimit,
  input  logic [HARD_W-1:0]  hardLimit,
  input  logic [STRAP_W-1:0] strapIn,
  input  logic               clrSoftStatus,
  input  logic               clrHardStatus,
  input  cnt_flag_t          flags,
  output cnt_cmd_t           cmd,
  output logic               resetOut,
  output logic               softStatus,
  output logic               hardStatus,
  output logic               bandCommit,
  output logic               safeSelect,
  output logic               cpuModeClr,
  output logic               agpModeClr,
  output logic               relatchStrobe,
  output logic [STRAP_W-1:0] strapValue
);

  localparam int RC_W = $clog2(RST_LEN + 1);

  logic            restart, softOn, hardOn, softHit, hardHit;
  logic            softDone, hardDone;
  logic [RC_W-1:0] rstCnt;

  always_comb begin
    restart     = kick | ~wdEnable;
    softOn      = wdEnable & softEnable & (softLimit != '0);
    hardOn      = wdEnable & (hardLimit != '0);
    cmd.softClr = restart | ~softOn;
    cmd.hardClr = restart | ~hardOn;
    cmd.softInc = tick & softOn & ~softDone & ~restart;
    cmd.hardInc = tick & hardOn & ~hardDone & ~restart;
    softHit     = cmd.softInc & flags.softAtLimit;
    hardHit     = cmd.hardInc & flags.hardAtLimit;
  end

  // A stage stays expired until the next service or disable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softDone <= 1'b0;
      hardDone <= 1'b0;
    end else if (restart) begin
      softDone <= 1'b0;
      hardDone <= 1'b0;
    end else begin
      if (softHit) softDone <= 1'b1;
      if (hardHit) hardDone <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bandCommit    <= 1'b0;
      safeSelect    <= 1'b0;
      cpuModeClr    <= 1'b0;
      agpModeClr    <= 1'b0;
      relatchStrobe <= 1'b0;
    end else begin
      bandCommit    <= softHit;
      safeSelect    <= hardHit;
      cpuModeClr    <= hardHit;
      agpModeClr    <= hardHit;
      relatchStrobe <= hardHit & relatchEnable;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         strapValue <= '0;
    else if (hardHit && relatchEnable) strapValue <= strapIn;
  end

  // Sticky status, the set wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softStatus <= 1'b0;
      hardStatus <= 1'b0;
    end else begin
      softStatus <= softHit | (softStatus & ~clrSoftStatus);
      hardStatus <= hardHit | (hardStatus & ~clrHardStatus);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rstCnt <= '0;
    else if (softHit | hardHit) rstCnt <= RC_W'(RST_LEN);
    else if (rstCnt != '0)     rstCnt <= rstCnt - 1'b1;
  end

  assign resetOut = (rstCnt != '0);

  p_reset_follows_r3: assert property (@(posedge clk) disable iff (!rstN)
    (softHit || hardHit) |=> resetOut);
  p_reset_min_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetOut) |=> resetOut);
  p_status_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (softStatus && !clrSoftStatus) |=> softStatus);
  p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wdEnable |=> (!bandCommit && !safeSelect));
  p_relatch_hard_r5: assert property (@(posedge clk) disable iff (!rstN)
    relatchStrobe |-> (safeSelect && cpuModeClr && agpModeClr));

endmodule

// File: rtl/wdog_alarm_top.sv
module wdog_alarm_top
  import wdog_alarm_pkg::*;
#(
  parameter int SOFT_W  = 4,
  parameter int HARD_W  = 8,
  parameter int STRAP_W = 3,
  parameter int RST_LEN = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               kick,
  input  logic               wdEnable,
  input  logic               softEnable,
  input  logic               relatchEnable,
  input  logic [SOFT_W-1:0]  softLimit,
  input  logic [HARD_W-1:0]  hardLimit,
  input  logic [STRAP_W-1:0] strapIn,
  input  logic               clrSoftStatus,
  input  logic               clrHardStatus,
  output logic               resetOut,
  output logic               softStatus,
  output logic               hardStatus,
  output logic               bandCommit,
  output logic               safeSelect,
  output logic               cpuModeClr,
  output logic               agpModeClr,
  output logic               relatchStrobe,
  output logic [STRAP_W-1:0] strapValue
);

  cnt_cmd_t  cmd;
  cnt_flag_t flags;

  wdog_alarm_dp #(.SOFT_W(SOFT_W), .HARD_W(HARD_W)) dp_i (
    .clk(clk), .rstN(rstN),
    .softLimit(softLimit), .hardLimit(hardLimit),
    .cmd(cmd), .flags(flags)
  );

  wdog_alarm_ctl #(.SOFT_W(SOFT_W), .HARD_W(HARD_W), .STRAP_W(STRAP_W), .RST_LEN(RST_LEN)) ctl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .kick(kick),
    .wdEnable(wdEnable), .softEnable(softEnable), .relatchEnable(relatchEnable),
    .softLimit(softLimit), .hardLimit(hardLimit), .strapIn(strapIn),
    .clrSoftStatus(clrSoftStatus), .clrHardStatus(clrHardStatus),
    .flags(flags), .cmd(cmd),
    .resetOut(resetOut), .softStatus(softStatus), .hardStatus(hardStatus),
    .bandCommit(bandCommit), .safeSelect(safeSelect),
    .cpuModeClr(cpuModeClr), .agpModeClr(agpModeClr),
    .relatchStrobe(relatchStrobe), .strapValue(strapValue)
  );

  // R7: a service cycle never produces an alarm strobe on the next cycle
  p_kick_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> (!bandCommit && !safeSelect));

endmodule

// File: tb/wdog_alarm_top_tb.sv
module wdog_alarm_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0, kick = 1'b0;
  logic       wdEnable = 1'b0, softEnable = 1'b0, relatchEnable = 1'b0;
  logic [3:0] softLimit = '0;
  logic [7:0] hardLimit = '0;
  logic [2:0] strapIn = '0;
  logic       clrSoftStatus = 1'b0, clrHardStatus = 1'b0;
  logic       resetOut, softStatus, hardStatus, bandCommit, safeSelect;
  logic       cpuModeClr, agpModeClr, relatchStrobe;
  logic [2:0] strapValue;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  // reference model state
  bit started = 0;
  int mS = 0, mH = 0;
  bit mSD = 0, mHD = 0;
  bit eBand = 0, eSafe = 0, eRel = 0, eSoftSt = 0, eHardSt = 0;
  int eRc = 0;
  logic [2:0] eStrap = '0;

  // event counters seen at the outputs
  int bandCount = 0, safeCount = 0, rstHigh = 0;

  always #2 clk = ~clk;

  wdog_alarm_top dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .kick(kick),
    .wdEnable(wdEnable), .softEnable(softEnable), .relatchEnable(relatchEnable),
    .softLimit(softLimit), .hardLimit(hardLimit), .strapIn(strapIn),
    .clrSoftStatus(clrSoftStatus), .clrHardStatus(clrHardStatus),
    .resetOut(resetOut), .softStatus(softStatus), .hardStatus(hardStatus),
    .bandCommit(bandCommit), .safeSelect(safeSelect),
    .cpuModeClr(cpuModeClr), .agpModeClr(agpModeClr),
    .relatchStrobe(relatchStrobe), .strapValue(strapValue)
  );

  task automatic chk(input int got, input int exp, input string tag);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Reference model, written from the requirements
  always @(posedge clk) begin
    bit sHit, hHit, softOn, hardOn;
    started = 1;
    if (!rstN) begin
      mS = 0; mH = 0; mSD = 0; mHD = 0;
      eBand = 0; eSafe = 0; eRel = 0; eSoftSt = 0; eHardSt = 0; eRc = 0; eStrap = '0;
    end else begin
      sHit = 0; hHit = 0;
      softOn = wdEnable && softEnable && (softLimit != 0);
      hardOn = wdEnable && (hardLimit != 0);
      if (kick || !wdEnable) begin
        mS = 0; mH = 0; mSD = 0; mHD = 0;
      end else begin
        if (!softOn) mS = 0;
        else if (tick && !mSD) begin
          mS++;
          if (mS >= int'(softLimit)) begin sHit = 1; mSD = 1; end
        end
        if (!hardOn) mH = 0;
        else if (tick && !mHD) begin
          mH++;
          if (mH >= int'(hardLimit)) begin hHit = 1; mHD = 1; end
        end
      end
      eBand = sHit;
      eSafe = hHit;
      eRel  = hHit && relatchEnable;
      if (eRel) eStrap = strapIn;
      eSoftSt = sHit ? 1'b1 : (clrSoftStatus ? 1'b0 : eSoftSt);
      eHardSt = hHit ? 1'b1 : (clrHardStatus ? 1'b0 : eHardSt);
      eRc = (sHit || hHit) ? 4 : ((eRc > 0) ? eRc - 1 : 0);
    end
  end

  // Compare every output away from the active edge
  always @(negedge clk) begin
    if (started && !finished) begin
      chk(int'(resetOut), int'(eRc != 0), "R3 resetOut");
      chk(int'(bandCommit), int'(eBand), "R2 bandCommit");
      chk(int'(softStatus), int'(eSoftSt), "R11 softStatus");
      chk(int'(hardStatus), int'(eHardSt), "R11 hardStatus");
      chk(int'(safeSelect), int'(eSafe), "R4 safeSelect");
      chk(int'(cpuModeClr), int'(eSafe), "R4 cpuModeClr");
      chk(int'(agpModeClr), int'(eSafe), "R4 agpModeClr");
      chk(int'(relatchStrobe), int'(eRel), "R5 relatchStrobe");
      chk(int'(strapValue), int'(eStrap), "R5 strapValue");
      if (bandCommit) bandCount++;
      if (safeSelect) safeCount++;
      if (resetOut)   rstHigh++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseTick(input int gap);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    idle(gap);
  endtask

  task automatic pulseKick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic settle();
    idle(2);
    #1;
  endtask

  initial begin
    int b0, s0, r0;
    void'($urandom(32'd20240611));

    // R1: reset state
    idle(3); #1;
    chk(int'({resetOut, softStatus, hardStatus, bandCommit, safeSelect,
              cpuModeClr, agpModeClr, relatchStrobe}), 0, "R1 outputs in reset");
    chk(int'(strapValue), 0, "R1 strapValue in reset");
    @(negedge clk); rstN = 1'b1;
    settle();
    chk(int'({resetOut, softStatus, hardStatus, bandCommit, safeSelect}), 0, "R1 after release");

    // R2 R4 R5: soft at 2, hard at 5, relatch on
    wdEnable = 1; softEnable = 1; relatchEnable = 1;
    softLimit = 4'd2; hardLimit = 8'd5; strapIn = 3'b101;
    pulseKick();
    b0 = bandCount; s0 = safeCount;
    pulseTick(1); pulseTick(1); settle();
    chk(bandCount - b0, 1, "R2 soft alarm after 2 ticks");
    chk(safeCount - s0, 0, "R4 no hard alarm yet");
    pulseTick(1); pulseTick(1); pulseTick(1); settle();
    chk(safeCount - s0, 1, "R4 hard alarm after 5 ticks");
    chk(int'(strapValue), 5, "R5 straps captured");
    // R10: no further alarms
    for (int i = 0; i < 8; i++) pulseTick(0);
    settle();
    chk(bandCount - b0, 1, "R10 soft once");
    chk(safeCount - s0, 1, "R10 hard once");
    // R11: clear statuses
    @(negedge clk); clrSoftStatus = 1; clrHardStatus = 1;
    @(negedge clk); clrSoftStatus = 0; clrHardStatus = 0;
    #1;
    chk(int'({softStatus, hardStatus}), 0, "R11 cleared");

    // R3: isolated soft alarm gives 4 reset cycles; R5 relatch off
    hardLimit = 8'd0; relatchEnable = 0; strapIn = 3'b010;
    pulseKick(); idle(6);
    r0 = rstHigh;
    pulseTick(2); pulseTick(8); settle();
    chk(rstHigh - r0, 4, "R3 reset length");

    // R6: soft disabled, hard still works, R5 straps unchanged without relatch
    softEnable = 0; hardLimit = 8'd4;
    pulseKick();
    b0 = bandCount; s0 = safeCount;
    for (int i = 0; i < 6; i++) pulseTick(1);
    settle();
    chk(bandCount - b0, 0, "R6 soft off");
    chk(safeCount - s0, 1, "R6 hard still fires");
    chk(int'(strapValue), 5, "R5 no relatch when disabled");

    // R7: frequent kicks and kick-with-tick
    softEnable = 1; softLimit = 4'd3; hardLimit = 8'd3;
    pulseKick();
    b0 = bandCount; s0 = safeCount;
    for (int i = 0; i < 10; i++) begin pulseTick(0); pulseTick(0); pulseKick(); end
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); tick = 1; kick = 1;
    end
    @(negedge clk); tick = 0; kick = 0;
    settle();
    chk(bandCount - b0, 0, "R7 kicks hold off soft");
    chk(safeCount - s0, 0, "R7 kicks hold off hard");

    // R8: disable holds, re-enable counts from zero
    wdEnable = 0;
    b0 = bandCount; s0 = safeCount;
    for (int i = 0; i < 20; i++) pulseTick(0);
    settle();
    chk(bandCount - b0 + safeCount - s0, 0, "R8 disabled quiet");
    wdEnable = 1; softEnable = 0;
    pulseTick(0); pulseTick(0); settle();
    chk(safeCount - s0, 0, "R8 restart from zero");
    pulseTick(0); settle();
    chk(safeCount - s0, 1, "R8 third tick fires");

    // R9: zero limits
    softEnable = 1; softLimit = 0; hardLimit = 0;
    pulseKick();
    b0 = bandCount; s0 = safeCount;
    for (int i = 0; i < 40; i++) pulseTick(0);
    settle();
    chk(bandCount - b0 + safeCount - s0, 0, "R9 zero limit off");

    // R11: set wins over clear in the same cycle
    softLimit = 4'd1; pulseKick();
    @(negedge clk); tick = 1; clrSoftStatus = 1;
    @(negedge clk); tick = 0; clrSoftStatus = 0;
    #1;
    chk(int'(softStatus), 1, "R11 set beats clear");

    // Constrained random phase, checked by the model every cycle
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      tick = ($urandom % 3) == 0;
      kick = ($urandom % 60) == 0;
      clrSoftStatus = ($urandom % 8) == 0;
      clrHardStatus = ($urandom % 8) == 0;
      strapIn = 3'($urandom);
      if (($urandom % 150) == 0) wdEnable = ~wdEnable;
      if (($urandom % 100) == 0) softEnable = ~softEnable;
      if (($urandom % 80) == 0) relatchEnable = ~relatchEnable;
      if (($urandom % 120) == 0) begin
        softLimit = 4'($urandom % 6);
        hardLimit = 8'(softLimit + ($urandom % 10));
      end
      if (!wdEnable && ($urandom % 4) == 0) wdEnable = 1;
    end
    tick = 0; kick = 0;
    settle();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      nFail++;
      $display("FAIL watchdog expired: got running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule